// File: doc/BRIEF.md
# Per-Stream Serial Launch Advance Unit

This block launches each of eight serial output streams a programmable number of system-clock cycles ahead of the nominal output frame boundary, while the frame boundary itself stays fixed. A frame timing generator outside the block supplies a reference strobe exactly three clock cycles before every frame boundary. From that reference the block produces one launch strobe per stream, then shifts that stream's frame word out serially starting on the launch cycle.

Each stream has a small configuration register on a simple read/write port. The register holds a two-bit advance value (0 to 3 cycles). Software writes a value at any time. The value becomes active only at the next frame boundary, so a frame already in progress is never cut short and never repeated. With an advance of zero, a stream launches on the boundary cycle itself, so it keeps its normal alignment with the frame pulse.

Top module: `stream_launch_advance`

## Requirements
- R1: After reset every advance register reads back as zero, every launch strobe is low and every serial output is low.
- R2: A write to address BASE_ADDR+n (n = 0..7) stores bits 1:0 of the write data as the advance for stream n. A read of that address returns the stored value, zero-extended to 16 bits, on `cfg_rdata` in the cycle after `cfg_rd_en`. If a write hits the same address in the same cycle, the read returns the value held before that write.
- R3: Write-data bits 15:2 are discarded, and read-data bits 15:2 are always zero.
- R4: Writes to addresses outside BASE_ADDR..BASE_ADDR+7 leave all eight registers unchanged, and reads of such addresses return zero.
- R5: Let advance a be the active value of stream n, and let the reference strobe be high in cycle t. Then `launch_o[n]` is high for exactly one cycle, in cycle t+3-a. The frame boundary is cycle t+3, so a = 3 launches in cycle t itself.
- R6: A stored advance value becomes active on the clock edge at the end of the boundary cycle (t+3). Launches inside the window t..t+3 always use the value that was active before the window.
- R7: From the launch cycle L, the frame word sampled in cycle L is sent MSB first. Bit k of the frame (k = 0 being the MSB) is driven during cycles L+4k .. L+4k+3 (BIT_CYC = 4). After the last bit the output is 0. Every bit of the frame moves by the same advance.
- R8: Each stream follows only its own advance value. Stream n takes its frame word from `stream_word_i[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data, valid one cycle after the read strobe |
| pre_ref_i | input | 1 | Reference strobe, three cycles before each frame boundary |
| stream_word_i | input | 64 | Frame word per stream, 8 bits each, sampled on that stream's launch cycle |
| launch_o | output | 8 | One-cycle launch strobe per stream |
| ser_o | output | 8 | Serial data per stream |

## Verification
Each result is due at a known cycle, and every check is made in that cycle:
- Read data is due in the cycle after the read strobe.
- A launch strobe is due 3-a cycles after the reference. For an advance of 3 it is due in the reference cycle itself, since that path is combinational.
- Serial bit k is due from launch plus 4k cycles onward.
- A new advance value first affects the launch after the boundary edge.

The bench drives inputs 1 ns after each rising edge and samples outputs 1 ns later. It steps a cycle-accurate reference model once per cycle. That model keeps the stored and the active advance values apart and copies one to the other only at the end of a boundary cycle.

// File: rtl/sla_pkg.sv
package sla_pkg;
    localparam int ADV_W   = 2;
    localparam int MAX_ADV = (1 << ADV_W) - 1;
    typedef logic [ADV_W-1:0] adv_t;
endpackage

// File: rtl/sla_reg_bank.sv
module sla_reg_bank
    import sla_pkg::*;
#(
    parameter int          NUM_STREAMS = 8,
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 16,
    parameter logic [7:0]  BASE_ADDR   = 8'h20
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en_i,
    input  logic                                rd_en_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    input  logic                                boundary_i,
    output logic [DATA_W-1:0]                   rdata_o,
    output logic [NUM_STREAMS-1:0][ADV_W-1:0]   adv_act_o
);
    localparam int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

    typedef struct packed {
        logic [NUM_STREAMS-1:0][ADV_W-1:0] stored;
        logic [NUM_STREAMS-1:0][ADV_W-1:0] active;
        logic [DATA_W-1:0]                 rdata;
    } bank_t;

    bank_t state_d, state_q;

    logic [ADDR_W-1:0] offset;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        offset  = addr_i - ADDR_W'(BASE_ADDR);
        hit     = offset < ADDR_W'(NUM_STREAMS);
        idx     = offset[IDX_W-1:0];
        state_d = state_q;
        // pending values move to the active set only at a frame boundary
        if (boundary_i) begin
            state_d.active = state_q.stored;
        end
        if (rd_en_i) begin
            state_d.rdata = hit ? DATA_W'(state_q.stored[idx]) : '0;
        end
        // truncating cast drops the reserved bits
        if (wr_en_i && hit) begin
            state_d.stored[idx] = adv_t'(wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o   = state_q.rdata;
    assign adv_act_o = state_q.active;
endmodule

// File: rtl/sla_ref_taps.sv
module sla_ref_taps
    import sla_pkg::*;
#(
    parameter int DEPTH = MAX_ADV
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_ref_i,
    output logic [DEPTH:0] taps_o,
    output logic           boundary_o
);
    typedef struct packed {
        logic [DEPTH-1:0] dly;
    } taps_st_t;

    taps_st_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.dly[0] = pre_ref_i;
        for (int k = 1; k < DEPTH; k++) begin
            state_d.dly[k] = state_q.dly[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // tap k is the reference delayed by k cycles; the last tap marks the boundary
    assign taps_o     = {state_q.dly, pre_ref_i};
    assign boundary_o = state_q.dly[DEPTH-1];
endmodule

// File: rtl/sla_stream_tx.sv
module sla_stream_tx
    import sla_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int BIT_CYC    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MAX_ADV:0]      taps_i,
    input  adv_t                  adv_i,
    input  logic [FRAME_BITS-1:0] word_i,
    output logic                  launch_o,
    output logic                  ser_o
);
    localparam int CYC_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [CYC_W-1:0]      cyc_cnt;
        logic [BIT_W-1:0]      bit_cnt;
        logic                  busy;
    } tx_t;

    tx_t  state_d, state_q;
    tx_t  cur;
    adv_t tap_sel;
    logic launch;

    always_comb begin
        tap_sel = adv_t'(MAX_ADV) - adv_i;
        launch  = taps_i[tap_sel];
        // the launch cycle is already the first cycle of bit 0
        if (launch) begin
            cur.shreg   = word_i;
            cur.cyc_cnt = '0;
            cur.bit_cnt = '0;
            cur.busy    = 1'b1;
        end else begin
            cur = state_q;
        end
        state_d = cur;
        if (cur.busy) begin
            if (cur.cyc_cnt == CYC_W'(BIT_CYC - 1)) begin
                state_d.cyc_cnt = '0;
                state_d.shreg   = cur.shreg << 1;
                state_d.bit_cnt = cur.bit_cnt + 1'b1;
                if (cur.bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
                    state_d.busy = 1'b0;
                end
            end else begin
                state_d.cyc_cnt = cur.cyc_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign launch_o = launch;
    assign ser_o    = cur.busy & cur.shreg[FRAME_BITS-1];
endmodule

// File: rtl/stream_launch_advance.sv
module stream_launch_advance
    import sla_pkg::*;
#(
    parameter int          NUM_STREAMS = 8,
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 16,
    parameter logic [7:0]  BASE_ADDR   = 8'h20,
    parameter int          FRAME_BITS  = 8,
    parameter int          BIT_CYC     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr_en,
    input  logic                              cfg_rd_en,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [DATA_W-1:0]                 cfg_rdata,
    input  logic                              pre_ref_i,
    input  logic [NUM_STREAMS*FRAME_BITS-1:0] stream_word_i,
    output logic [NUM_STREAMS-1:0]            launch_o,
    output logic [NUM_STREAMS-1:0]            ser_o
);
    logic [NUM_STREAMS-1:0][ADV_W-1:0] adv_act;
    logic [MAX_ADV:0]                  taps;
    logic                              boundary;

    sla_ref_taps #(.DEPTH(MAX_ADV)) u_taps (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_ref_i  (pre_ref_i),
        .taps_o     (taps),
        .boundary_o (boundary)
    );

    sla_reg_bank #(
        .NUM_STREAMS (NUM_STREAMS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BASE_ADDR   (BASE_ADDR)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cfg_wr_en),
        .rd_en_i    (cfg_rd_en),
        .addr_i     (cfg_addr),
        .wdata_i    (cfg_wdata),
        .boundary_i (boundary),
        .rdata_o    (cfg_rdata),
        .adv_act_o  (adv_act)
    );

    for (genvar n = 0; n < NUM_STREAMS; n++) begin : g_stream
        sla_stream_tx #(
            .FRAME_BITS (FRAME_BITS),
            .BIT_CYC    (BIT_CYC)
        ) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .taps_i   (taps),
            .adv_i    (adv_act[n]),
            .word_i   (stream_word_i[n*FRAME_BITS +: FRAME_BITS]),
            .launch_o (launch_o[n]),
            .ser_o    (ser_o[n])
        );
    end
endmodule

// File: rtl/sla_chk.sv
module sla_chk
    import sla_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int DATA_W      = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              pre_ref_i,
    input logic [NUM_STREAMS-1:0]            launch_o,
    input logic                              cfg_rd_en,
    input logic [DATA_W-1:0]                 cfg_rdata,
    input logic [NUM_STREAMS-1:0][ADV_W-1:0] adv_act,
    input logic                              boundary
);
    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> ((cfg_rdata >> ADV_W) == '0));

    // R6
    adv_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adv_act) |-> $past(boundary));

    for (genvar n = 0; n < NUM_STREAMS; n++) begin : g_s
        // R5
        launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            launch_o[n] |=> !launch_o[n]);
        if (ADV_W == 2) begin : g_two
            // R5
            launch_adv0_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (launch_o[n] && adv_act[n] == 2'd0) |-> $past(pre_ref_i, 3));
            // R5
            launch_adv1_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (launch_o[n] && adv_act[n] == 2'd1) |-> $past(pre_ref_i, 2));
            // R5
            launch_adv2_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (launch_o[n] && adv_act[n] == 2'd2) |-> $past(pre_ref_i, 1));
            // R5
            launch_adv3_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (launch_o[n] && adv_act[n] == 2'd3) |-> pre_ref_i);
        end
    end
endmodule

bind stream_launch_advance sla_chk #(
    .NUM_STREAMS (NUM_STREAMS),
    .DATA_W      (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_ref_i (pre_ref_i),
    .launch_o  (launch_o),
    .cfg_rd_en (cfg_rd_en),
    .cfg_rdata (cfg_rdata),
    .adv_act   (adv_act),
    .boundary  (boundary)
);

// File: tb/stream_launch_advance_tb_top.sv
`timescale 1ns/1ps
module stream_launch_advance_tb_top;
    localparam int NS   = 8;
    localparam int FB   = 8;
    localparam int BC   = 4;
    localparam int BASE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        pre_ref_i = 1'b0;
    logic [NS*FB-1:0] stream_word_i = '0;
    logic [NS-1:0] launch_o;
    logic [NS-1:0] ser_o;

    always #2 clk = ~clk;

    stream_launch_advance dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pre_ref_i(pre_ref_i), .stream_word_i(stream_word_i),
        .launch_o(launch_o), .ser_o(ser_o)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    int      stored [NS];
    int      active [NS];
    bit      hist [4];
    int      launch_cyc [NS];
    bit [FB-1:0] cap_word [NS];
    int      cyc = 0;
    bit      rd_pend = 1'b0;
    int      rd_exp = 0;
    string   rd_tag = "R2";
    bit      r1_phase = 1'b1;

    task automatic check(input string tag, input int actual, input int expected);
        nchk++;
        if (actual != expected) begin
            nerr++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, actual, expected);
        end
    endtask

    function automatic int addr_idx(input logic [7:0] a);
        int off = int'(a) - BASE;
        return (off >= 0 && off < NS) ? off : -1;
    endfunction

    task automatic step(input bit pre, input bit wr, input bit rd,
                        input logic [7:0] addr, input logic [15:0] wd);
        @(posedge clk);
        #1;
        pre_ref_i = pre; cfg_wr_en = wr; cfg_rd_en = rd;
        cfg_addr = addr; cfg_wdata = wd;
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = pre;
        #1;
        for (int n = 0; n < NS; n++) begin
            bit el = hist[3 - active[n]];
            int kb;
            int es = 0;
            if (el) begin
                launch_cyc[n] = cyc;
                cap_word[n] = stream_word_i[n*FB +: FB];
            end
            if (launch_cyc[n] >= 0) begin
                kb = (cyc - launch_cyc[n]) / BC;
                if (kb < FB) es = cap_word[n][FB-1-kb];
            end
            if (r1_phase) begin
                check("R1", int'(launch_o[n]), 0);
                check("R1", int'(ser_o[n]), 0);
            end else begin
                check((stored[n] != active[n]) ? "R6" : "R5", int'(launch_o[n]), int'(el));
                check("R7", int'(ser_o[n]), es);
            end
        end
        if (rd_pend) begin
            check(rd_tag, int'(cfg_rdata), rd_exp);
            check("R3", int'(cfg_rdata[15:2]), 0);
        end
        rd_pend = rd;
        if (rd) begin
            int i = addr_idx(addr);
            rd_exp = (i >= 0) ? stored[i] : 0;
            rd_tag = r1_phase ? "R1" : ((i >= 0) ? "R2" : "R4");
        end
        if (hist[3]) for (int n = 0; n < NS; n++) active[n] = stored[n];
        if (wr) begin
            int i = addr_idx(addr);
            if (i >= 0) stored[i] = int'(wd[1:0]);
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
    endtask

    task automatic frame(input int len);
        step(1'b1, 1'b0, 1'b0, 8'h00, 16'h0);
        for (int k = 1; k < len; k++) begin
            if (k == 12) stream_word_i = {$urandom, $urandom};
            step(1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
        end
    endtask

    task automatic read_all();
        for (int n = 0; n < NS; n++) step(1'b0, 1'b0, 1'b1, 8'(BASE + n), 16'h0);
        idle(1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < NS; n++) begin
            stored[n] = 0; active[n] = 0; launch_cyc[n] = -1; cap_word[n] = '0;
        end
        for (int k = 0; k < 4; k++) hist[k] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: registers and outputs are zero after reset
        idle(2);
        read_all();
        r1_phase = 1'b0;
        stream_word_i = {$urandom, $urandom};
        frame(32);
        frame(32);
        // R2 R3 R8: distinct advance per stream, reserved bits set
        for (int n = 0; n < NS; n++)
            step(1'b0, 1'b1, 1'b0, 8'(BASE + n), 16'hFFFC | 16'(n % 4));
        read_all();
        frame(32);
        frame(33);
        frame(35);
        // R6: change stream 0 and 3 inside the launch window
        step(1'b1, 1'b1, 1'b0, 8'(BASE), 16'h0003);
        step(1'b0, 1'b1, 1'b0, 8'(BASE + 3), 16'h0000);
        step(1'b0, 1'b1, 1'b1, 8'(BASE), 16'h0001);
        for (int k = 3; k < 32; k++) step(1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
        frame(32);
        frame(32);
        // R4: out-of-range addresses
        step(1'b0, 1'b1, 1'b0, 8'(BASE + NS), 16'h0003);
        step(1'b0, 1'b1, 1'b0, 8'(BASE - 1), 16'h0003);
        step(1'b0, 1'b1, 1'b1, 8'hFF, 16'h0002);
        step(1'b0, 1'b0, 1'b1, 8'(BASE + NS), 16'h0);
        read_all();
        frame(32);
        // R7 R5 R6: random traffic
        for (int f = 0; f < 60; f++) begin
            int len = 32 + int'($urandom_range(0, 5));
            for (int k = 0; k < len; k++) begin
                bit op = ($urandom_range(0, 5) == 0);
                bit wr = op && $urandom_range(0, 1) == 1;
                bit rd = op && !wr ? 1'b1 : ($urandom_range(0, 7) == 0);
                logic [7:0] a = 8'(BASE - 2 + int'($urandom_range(0, NS + 3)));
                if (k == 12) stream_word_i = {$urandom, $urandom};
                step(k == 0, wr, rd, a, 16'($urandom));
            end
        end
        read_all();
        idle(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule